// File: doc/BRIEF.md
# Floating-Point Compare and Flag Mapper

The block compares two operands held in 80-bit extended real format. The first is the stack-top operand and the second is the source operand. It sorts the pair into one of four relations: greater, less, equal or unordered. For each compare it writes the relation in one of two places, chosen per request. The status-word form writes the condition bits C3, C2, C1 and C0. The direct form writes the integer zero, parity and carry flags without passing through the status word.

The flags carry no sign or overflow information, so the relation is tested the way unsigned integers are: above, below or equal. A NaN on either side gives the distinct unordered result and raises the invalid indication. Positive and negative zero compare equal. A compare may also ask for a pop. The block then issues one pop request alongside the result and leaves the stack handling to its neighbour.

Operand layout: bit 79 is the sign, bits 78:64 are the biased exponent, and bits 63:0 are the significand with an explicit integer bit at bit 63. Results are registered and appear one clock after the request.

Top module: `fcmp_flagmap`

## Requirements
- R1: A compare accepted on a rising edge with `in_valid` high raises `out_valid` for exactly the following cycle. `out_valid` is low in any cycle that does not follow an accepted compare.
- R2: A status-form compare (`in_direct`=0) loads `out_cc`, where bit 3 is C3, bit 2 is C2, bit 1 is C1 and bit 0 is C0. The outcome sets {C3,C2,C0} as follows: greater gives 000, less gives 001, equal gives 100 and unordered gives 111. "Greater" means stack-top > source.
- R3: Every status-form compare clears C1 (`out_cc[1]`=0).
- R4: A direct-form compare (`in_direct`=1) sets `out_zf` to the C3 value of the outcome, `out_pf` to the C2 value and `out_cf` to the C0 value, and leaves `out_cc` unchanged. A status-form compare leaves the three flags unchanged. Cycles without an accepted compare change neither.
- R5: An operand is a NaN when its exponent is all ones and significand bits 62:0 are not all zero. If either operand is a NaN, the outcome is unordered and `out_invalid` is high in the result cycle. `out_invalid` is low in every other case.
- R6: An operand with exponent and significand both zero is a zero. Two zeros compare equal whatever their signs.
- R7: Among non-NaN operands that are not both zero, a positive operand is greater than a negative one. Two operands of the same sign are ordered by exponent, then by significand, and the order is reversed when both are negative. An infinity (exponent all ones, significand bits 62:0 zero) orders as the largest magnitude.
- R8: A compare accepted with `in_pop` high raises `out_pop` for its result cycle only. `out_pop` is never high outside a result cycle or for a compare without `in_pop`.
- R9: While `rst` is high at a rising edge, `out_cc`, the three flags, `out_valid`, `out_invalid` and `out_pop` are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request |
| in_direct | input | 1 | 1: write integer flags, 0: write condition bits |
| in_pop | input | 1 | Request a pop after this compare |
| in_st0 | input | 80 | Stack-top operand |
| in_src | input | 80 | Source operand |
| out_valid | output | 1 | Result cycle marker |
| out_cc | output | 4 | Condition bits {C3,C2,C1,C0} |
| out_zf | output | 1 | Zero flag |
| out_pf | output | 1 | Parity flag |
| out_cf | output | 1 | Carry flag |
| out_invalid | output | 1 | Invalid indication for an unordered compare |
| out_pop | output | 1 | Single pop request |

## Verification
The assertions assume that the mode and pop inputs are meaningful only together with `in_valid`. They also assume that operand encodings outside the NaN, zero and infinity classes are ordinary values ordered by their raw exponent and significand bits. The stimulus drives every input on the falling edge and holds it for one full cycle. Each compare is followed by an idle cycle in which the operands carry unrelated values, which shows that idle inputs are ignored. Every operand in the vector table is a well-formed normal, denormal, zero, infinity or quiet NaN, so the assumptions hold throughout.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_zero;
    } opclass_t;

    // {C3, C2, C0} for a relation
    function automatic logic [2:0] rel_bits(input rel_e rel);
        case (rel)
            REL_GT:  return 3'b000;
            REL_LT:  return 3'b001;
            REL_EQ:  return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int OP_W  = 1 + EXP_W + SIG_W,
    localparam int MAG_W = EXP_W + SIG_W
) (
    input  logic [OP_W-1:0]  op,
    output opclass_t         cls,
    output logic [MAG_W-1:0] mag
);
    logic [EXP_W-1:0] expo;
    logic [SIG_W-1:0] sig;

    always_comb begin
        expo        = op[OP_W-2 -: EXP_W];
        sig         = op[SIG_W-1:0];
        cls.sign    = op[OP_W-1];
        cls.is_nan  = (&expo) && (|sig[SIG_W-2:0]);
        cls.is_zero = (expo == '0) && (sig == '0);
        mag         = {expo, sig};
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 79
) (
    input  opclass_t         cls_a,
    input  opclass_t         cls_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output rel_e             rel
);
    logic mag_gt;
    logic mag_eq;

    always_comb begin
        mag_gt = mag_a > mag_b;
        mag_eq = mag_a == mag_b;
        if (cls_a.is_nan || cls_b.is_nan)
            rel = REL_UN;
        else if (cls_a.is_zero && cls_b.is_zero)
            rel = REL_EQ;
        else if (cls_a.sign != cls_b.sign)
            rel = cls_a.sign ? REL_LT : REL_GT;
        else if (mag_eq)
            rel = REL_EQ;
        else if (mag_gt ^ cls_a.sign)
            rel = REL_GT;
        else
            rel = REL_LT;
    end
endmodule

// File: rtl/fcmp_flagmap.sv
module fcmp_flagmap
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int OP_W  = 1 + EXP_W + SIG_W,
    localparam int MAG_W = EXP_W + SIG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_direct,
    input  logic            in_pop,
    input  logic [OP_W-1:0] in_st0,
    input  logic [OP_W-1:0] in_src,
    output logic            out_valid,
    output logic [3:0]      out_cc,
    output logic            out_zf,
    output logic            out_pf,
    output logic            out_cf,
    output logic            out_invalid,
    output logic            out_pop
);
    logic [OP_W-1:0]  ops  [2];
    opclass_t         cls  [2];
    logic [MAG_W-1:0] mags [2];
    rel_e             rel;
    logic [2:0]       bits;

    assign ops[0] = in_st0;
    assign ops[1] = in_src;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
            .op  (ops[g]),
            .cls (cls[g]),
            .mag (mags[g])
        );
    end

    fcmp_order #(.MAG_W(MAG_W)) u_ord (
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .mag_a (mags[0]),
        .mag_b (mags[1]),
        .rel   (rel)
    );

    assign bits = rel_bits(rel);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_invalid <= 1'b0;
            out_pop     <= 1'b0;
            out_cc      <= '0;
            out_zf      <= 1'b0;
            out_pf      <= 1'b0;
            out_cf      <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_invalid <= in_valid && (rel == REL_UN);
            out_pop     <= in_valid && in_pop;
            if (in_valid && !in_direct)
                out_cc <= {bits[2], bits[1], 1'b0, bits[0]};
            if (in_valid && in_direct) begin
                out_zf <= bits[2];
                out_pf <= bits[1];
                out_cf <= bits[0];
            end
        end
    end

    // R5: a NaN on either side must yield the unordered relation
    a_r5_nan_unordered: assert property (@(posedge clk) disable iff (rst)
        (cls[0].is_nan || cls[1].is_nan) |-> rel == REL_UN);

    // R6: two zeros of any sign compare equal
    a_r6_zero_equal: assert property (@(posedge clk) disable iff (rst)
        (cls[0].is_zero && cls[1].is_zero) |-> rel == REL_EQ);

    // R1: a request produces a result marker on the next cycle and only then
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_valid_origin: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8: pop request only within a result cycle
    a_r8_pop_in_result: assert property (@(posedge clk) disable iff (rst)
        out_pop |-> out_valid);

    // R5: invalid only within a result cycle
    a_r5_invalid_in_result: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> out_valid);

    // R4: condition bits hold unless a status-form compare arrives
    a_r4_cc_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && !in_direct) |=> $stable(out_cc));

    // R4: integer flags hold unless a direct-form compare arrives
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_direct) |=> $stable({out_zf, out_pf, out_cf}));

    // R3: C1 reads zero after any status-form compare
    a_r3_c1_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_direct) |=> !out_cc[1]);
endmodule

// File: tb/sim_fcmp_flagmap.sv
module sim_fcmp_flagmap;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_direct = 1'b0;
    logic        in_pop = 1'b0;
    logic [79:0] in_st0 = '0;
    logic [79:0] in_src = '0;
    logic        out_valid, out_zf, out_pf, out_cf, out_invalid, out_pop;
    logic [3:0]  out_cc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fcmp_flagmap u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_direct(in_direct),
        .in_pop(in_pop), .in_st0(in_st0), .in_src(in_src),
        .out_valid(out_valid), .out_cc(out_cc), .out_zf(out_zf),
        .out_pf(out_pf), .out_cf(out_cf), .out_invalid(out_invalid),
        .out_pop(out_pop)
    );

    localparam logic [79:0] V_ONE   = 80'h3FFF8000000000000000;
    localparam logic [79:0] V_ONEH  = 80'h3FFFC000000000000000;
    localparam logic [79:0] V_TWO   = 80'h40008000000000000000;
    localparam logic [79:0] V_MONE  = 80'hBFFF8000000000000000;
    localparam logic [79:0] V_MTWO  = 80'hC0008000000000000000;
    localparam logic [79:0] V_PZ    = 80'h00000000000000000000;
    localparam logic [79:0] V_NZ    = 80'h80000000000000000000;
    localparam logic [79:0] V_PINF  = 80'h7FFF8000000000000000;
    localparam logic [79:0] V_NINF  = 80'hFFFF8000000000000000;
    localparam logic [79:0] V_NAN   = 80'h7FFFC000000000000000;
    localparam logic [79:0] V_DEN   = 80'h00000000000000000001;

    // relation codes used by the bench: 0 greater, 1 less, 2 equal, 3 unordered
    typedef struct packed {
        logic [79:0] a;
        logic [79:0] b;
        logic [1:0]  rel;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{V_ONE,  V_TWO,  2'd1},   // R2
        '{V_TWO,  V_ONE,  2'd0},   // R2, R7 exponent
        '{V_ONE,  V_ONE,  2'd2},   // R2
        '{V_ONEH, V_ONE,  2'd0},   // R7 significand
        '{V_MONE, V_MTWO, 2'd0},   // R7 negative inversion
        '{V_MTWO, V_MONE, 2'd1},   // R7 negative inversion
        '{V_MONE, V_ONE,  2'd1},   // R7 sign
        '{V_ONE,  V_MTWO, 2'd0},   // R7 sign
        '{V_PZ,   V_NZ,   2'd2},   // R6
        '{V_NZ,   V_PZ,   2'd2},   // R6
        '{V_PINF, V_TWO,  2'd0},   // R7 infinity
        '{V_NINF, V_MTWO, 2'd1},   // R7 infinity
        '{V_NAN,  V_ONE,  2'd3},   // R5
        '{V_ONE,  V_NAN,  2'd3},   // R5
        '{V_DEN,  V_PZ,   2'd0},   // R7 denormal
        '{V_NZ,   V_DEN,  2'd1},   // R6/R7
        '{V_PINF, V_PINF, 2'd2}    // R7
    };

    function automatic logic [2:0] exp_bits(input logic [1:0] r);
        case (r)
            2'd0: return 3'b000;
            2'd1: return 3'b001;
            2'd2: return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one compare for one cycle, sample its result cycle
    task automatic issue(input logic [79:0] a, input logic [79:0] b,
                         input logic direct, input logic pop);
        @(negedge clk);
        in_valid  = 1'b1;
        in_direct = direct;
        in_pop    = pop;
        in_st0    = a;
        in_src    = b;
        @(negedge clk);
        in_valid  = 1'b0;
        in_pop    = 1'b0;
        in_st0    = 80'h5A5A_1234_0000_FFFF_8888;
        in_src    = 80'hFFFF_C000_0000_0000_0001;
    endtask

    logic [3:0] cc_exp;
    logic [2:0] fl_exp;

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 cc", {4'b0, out_cc}, 8'h00);
        check("R9 flags", {5'b0, out_zf, out_pf, out_cf}, 8'h00);
        check("R9 valid/inv/pop", {5'b0, out_valid, out_invalid, out_pop}, 8'h00);
        rst = 1'b0;
        cc_exp = 4'b0;
        fl_exp = 3'b0;

        for (int i = 0; i < NV; i++) begin
            logic [2:0] eb;
            eb = exp_bits(VECS[i].rel);
            // status form
            issue(VECS[i].a, VECS[i].b, 1'b0, i[0]);
            cc_exp = {eb[2], eb[1], 1'b0, eb[0]};
            check("R1 valid", {7'b0, out_valid}, 8'h01);
            check("R2/R3 cc", {4'b0, out_cc}, {4'b0, cc_exp});
            check("R4 flags held", {5'b0, out_zf, out_pf, out_cf}, {5'b0, fl_exp});
            check("R5 invalid", {7'b0, out_invalid}, {7'b0, VECS[i].rel == 2'd3});
            check("R8 pop", {7'b0, out_pop}, {7'b0, i[0]});
            // direct form
            issue(VECS[i].a, VECS[i].b, 1'b1, ~i[0]);
            fl_exp = eb;
            check("R4 flags", {5'b0, out_zf, out_pf, out_cf}, {5'b0, fl_exp});
            check("R4 cc held", {4'b0, out_cc}, {4'b0, cc_exp});
            check("R5 invalid direct", {7'b0, out_invalid}, {7'b0, VECS[i].rel == 2'd3});
            check("R8 pop direct", {7'b0, out_pop}, {7'b0, ~i[0]});
            // idle cycle: nothing moves
            @(negedge clk);
            check("R1 idle valid", {7'b0, out_valid}, 8'h00);
            check("R8 idle pop", {7'b0, out_pop}, 8'h00);
            check("R5 idle invalid", {7'b0, out_invalid}, 8'h00);
            check("R4 idle hold", {1'b0, out_cc, out_zf, out_pf, out_cf},
                  {1'b0, cc_exp, fl_exp});
        end

        // R1: back-to-back compares, second without pop
        @(negedge clk);
        in_valid = 1'b1; in_direct = 1'b0; in_pop = 1'b1;
        in_st0 = V_TWO; in_src = V_ONE;
        @(negedge clk);
        check("R2 back-to-back first", {4'b0, out_cc}, 8'h00);
        check("R8 back-to-back first pop", {7'b0, out_pop}, 8'h01);
        in_pop = 1'b0; in_st0 = V_ONE; in_src = V_TWO;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 back-to-back second", {7'b0, out_valid}, 8'h01);
        check("R2 back-to-back second", {4'b0, out_cc}, 8'h01);
        check("R8 back-to-back second pop", {7'b0, out_pop}, 8'h00);

        // R9: reset clears held results
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 re-reset", {1'b0, out_cc, out_zf, out_pf, out_cf}, 8'h00);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule